// File: doc/BRIEF.md
# Idle Interval Timer

This block is a free-running down-counter that advances once per instruction cycle. It gives the chip a steady time base for periodic wakeup and housekeeping interrupts. The counter never stops and never reloads. Software has no path to read it or write it. A fixed bit of the counter is watched, and every change of that bit is an interval event. Each event raises a one-cycle tick for neighbouring wakeup logic and sets a sticky pending flag.

Software sees two flags, and the flags are its only handle on the block. It can write the interrupt enable bit to any value. It can clear the pending flag by writing a zero to it. An interrupt request goes out only while the pending flag, the enable bit and the chip-wide global interrupt enable are all high. With the default parameters the counter is 16 bits wide and the watched bit is bit 12, so events arrive every 4096 enabled cycles.

Top module: `idle_tick_timer`

## Requirements
- R1: While `rstN` is low, `tick`, `pendFlag`, `intEnable` and `irq` are all 0. The internal counter starts at all ones.
- R2: `tick` is high for exactly the cycle that follows the clock edge completing the 4096th, 8192nd, 12288th, ... cycle in which `cycleEn` was sampled high since reset. It is low in every other cycle.
- R3: A clock edge at which `cycleEn` is low does not move the counter and never produces a tick.
- R4: `pendFlag` becomes 1 at the same edge that raises `tick`, whatever the value of `intEnable`.
- R5: `pendFlag` falls only at an edge where `ctlWrEn` is high and `ctlWrPend` is 0. A write with `ctlWrPend` = 1 leaves the flag unchanged.
- R6: If an interval event and a clearing write fall on the same edge, `pendFlag` is 1 after that edge.
- R7: At every edge with `ctlWrEn` high, `intEnable` takes the value of `ctlWrIntEn`. Otherwise it holds its value.
- R8: `irq` is combinationally equal to `pendFlag & intEnable & globalIntEn`.
- R9: `tick` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cycleEn | input | 1 | Instruction-cycle enable; the counter decrements on edges where it is high |
| ctlWrEn | input | 1 | Flag register write strobe |
| ctlWrIntEn | input | 1 | Value written to the interrupt enable bit |
| ctlWrPend | input | 1 | Pending bit of a write; 0 clears the flag, 1 leaves it |
| globalIntEn | input | 1 | Chip-wide interrupt enable |
| intEnable | output | 1 | Current interrupt enable bit |
| pendFlag | output | 1 | Sticky interval-event pending flag |
| irq | output | 1 | Interrupt request |
| tick | output | 1 | One-cycle pulse per watched-bit change |

## Verification
An interval event that sets the pending flag can share an edge with a software write that clears it. The bench tracks how many enabled cycles have gone by, so it knows which edge will carry the next event. On about half of those edges it issues a clearing write at that moment. It then expects the flag to read 1 after the edge. On every other edge it expects a clearing write to take the flag to 0.

// File: rtl/idle_tick_pkg.sv
package idle_tick_pkg;

  // Strobes issued by the control side to the counter datapath.
  typedef struct packed {
    logic advance;
  } ctlStrobes_t;

  // Events reported by the datapath back to control.
  typedef struct packed {
    logic toggle;
  } dpEvents_t;

endpackage

// File: rtl/idle_tick_dp.sv
module idle_tick_dp
  import idle_tick_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int TAP_BIT = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t strobes,
  output dpEvents_t   events,
  output logic        tickQ
);

  localparam logic [CNT_W-1:0] CNT_INIT = '1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cntNext;
  logic             tapFlip;

  // Decrement path; the counter wraps and never stops.
  always_comb begin
    cntNext = cnt - CNT_W'(1);
    tapFlip = cntNext[TAP_BIT] ^ cnt[TAP_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= CNT_INIT;
    end else if (strobes.advance) begin
      cnt <= cntNext;
    end
  end

  assign events.toggle = strobes.advance & tapFlip;

  always_ff @(posedge clk) begin
    if (!rstN) tickQ <= 1'b0;
    else       tickQ <= events.toggle;
  end

endmodule

// File: rtl/idle_tick_ctl.sv
module idle_tick_ctl
  import idle_tick_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cycleEn,
  input  logic        ctlWrEn,
  input  logic        ctlWrIntEn,
  input  logic        ctlWrPend,
  input  logic        globalIntEn,
  input  dpEvents_t   events,
  output ctlStrobes_t strobes,
  output logic        intEnable,
  output logic        pendFlag,
  output logic        irq
);

  logic clrReq;

  always_comb begin
    strobes.advance = cycleEn;
    clrReq          = ctlWrEn & ~ctlWrPend;
  end

  // Enable bit: plain software-written register.
  always_ff @(posedge clk) begin
    if (!rstN)        intEnable <= 1'b0;
    else if (ctlWrEn) intEnable <= ctlWrIntEn;
  end

  // Pending flag: hardware set takes priority over software clear.
  always_ff @(posedge clk) begin
    if (!rstN)              pendFlag <= 1'b0;
    else if (events.toggle) pendFlag <= 1'b1;
    else if (clrReq)        pendFlag <= 1'b0;
  end

  assign irq = pendFlag & intEnable & globalIntEn;

endmodule

// File: rtl/idle_tick_timer.sv
module idle_tick_timer
  import idle_tick_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int TAP_BIT = 12
) (
  input  logic clk,
  input  logic rstN,
  input  logic cycleEn,
  input  logic ctlWrEn,
  input  logic ctlWrIntEn,
  input  logic ctlWrPend,
  input  logic globalIntEn,
  output logic intEnable,
  output logic pendFlag,
  output logic irq,
  output logic tick
);

  ctlStrobes_t strobes;
  dpEvents_t   events;

  idle_tick_ctl u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .cycleEn    (cycleEn),
    .ctlWrEn    (ctlWrEn),
    .ctlWrIntEn (ctlWrIntEn),
    .ctlWrPend  (ctlWrPend),
    .globalIntEn(globalIntEn),
    .events     (events),
    .strobes    (strobes),
    .intEnable  (intEnable),
    .pendFlag   (pendFlag),
    .irq        (irq)
  );

  idle_tick_dp #(
    .CNT_W  (CNT_W),
    .TAP_BIT(TAP_BIT)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .events (events),
    .tickQ  (tick)
  );

endmodule

// File: rtl/idle_tick_checker.sv
module idle_tick_checker #(
  parameter int TAP_BIT = 12
) (
  input logic clk,
  input logic rstN,
  input logic cycleEn,
  input logic ctlWrEn,
  input logic ctlWrIntEn,
  input logic ctlWrPend,
  input logic globalIntEn,
  input logic intEnable,
  input logic pendFlag,
  input logic irq,
  input logic tick
);

  // Count enabled cycles modulo the event period.
  logic [TAP_BIT-1:0] sinceCnt;
  always_ff @(posedge clk) begin
    if (!rstN)        sinceCnt <= '0;
    else if (cycleEn) sinceCnt <= sinceCnt + TAP_BIT'(1);
  end

  assert_tick_period_R2: assert property (@(posedge clk) disable iff (!rstN)
    tick |-> (sinceCnt == '0));

  assert_tick_needs_en_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tick) |-> $past(cycleEn));

  assert_pend_on_tick_R4: assert property (@(posedge clk) disable iff (!rstN)
    tick |-> pendFlag);

  assert_pend_fall_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pendFlag) |-> $past(ctlWrEn && !ctlWrPend));

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rstN)
    (tick && $past(ctlWrEn && !ctlWrPend)) |-> pendFlag);

  assert_enable_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctlWrEn |=> (intEnable == $past(ctlWrIntEn)));

  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    irq == (pendFlag & intEnable & globalIntEn));

  assert_tick_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> !tick);

endmodule

bind idle_tick_timer idle_tick_checker #(.TAP_BIT(TAP_BIT)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cycleEn    (cycleEn),
  .ctlWrEn    (ctlWrEn),
  .ctlWrIntEn (ctlWrIntEn),
  .ctlWrPend  (ctlWrPend),
  .globalIntEn(globalIntEn),
  .intEnable  (intEnable),
  .pendFlag   (pendFlag),
  .irq        (irq),
  .tick       (tick)
);

// File: tb/idle_tick_timer_bench.sv
module idle_tick_timer_bench;

  localparam int PERIOD = 4096;
  localparam int NCYC   = 60000;

  logic clk = 1'b0;
  logic rstN, cycleEn, ctlWrEn, ctlWrIntEn, ctlWrPend, globalIntEn;
  logic intEnable, pendFlag, irq, tick;

  int checks = 0;
  int errors = 0;
  int nEn = 0;
  int nTicks = 0;
  int nRace = 0;
  logic tickExp, pendExp, enExp;
  bit done = 0;

  always #4 clk = ~clk;

  idle_tick_timer u_idle_tick_timer (
    .clk(clk), .rstN(rstN), .cycleEn(cycleEn), .ctlWrEn(ctlWrEn),
    .ctlWrIntEn(ctlWrIntEn), .ctlWrPend(ctlWrPend), .globalIntEn(globalIntEn),
    .intEnable(intEnable), .pendFlag(pendFlag), .irq(irq), .tick(tick)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  function automatic logic irqModel(logic p, logic e, logic g);
    return p & e & g;
  endfunction

  function automatic logic tickModel(int enSoFar, logic ce);
    return ce && (((enSoFar + 1) % PERIOD) == 0);
  endfunction

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 0; cycleEn = 1; ctlWrEn = 1; ctlWrIntEn = 1; ctlWrPend = 0; globalIntEn = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state, with inputs trying to disturb it
    chk("R1 tick", tick, 1'b0);
    chk("R1 pendFlag", pendFlag, 1'b0);
    chk("R1 intEnable", intEnable, 1'b0);
    chk("R1 irq", irq, 1'b0);
    rstN = 1; cycleEn = 0; ctlWrEn = 0; ctlWrIntEn = 0; ctlWrPend = 0; globalIntEn = 0;
    tickExp = 0; pendExp = 0; enExp = 0;

    for (int cyc = 0; cyc < NCYC; cyc++) begin
      logic upcoming;
      @(negedge clk);
      chk("R2/R3/R9 tick", tick, tickExp);
      chk("R4/R5/R6 pendFlag", pendFlag, pendExp);
      chk("R7 intEnable", intEnable, enExp);
      // Drive next inputs
      cycleEn = ($urandom % 4) != 0;
      if (cyc < 300) cycleEn = 0;          // R3: long idle stretch, no progress
      upcoming = tickModel(nEn, cycleEn);
      globalIntEn = $urandom % 2;
      if (upcoming && ($urandom % 2) == 0) begin
        ctlWrEn = 1; ctlWrPend = 0; ctlWrIntEn = $urandom % 2;   // R6 race
        nRace++;
      end else if (($urandom % 40) == 0) begin
        ctlWrEn = 1; ctlWrPend = $urandom % 2; ctlWrIntEn = $urandom % 2;
      end else begin
        ctlWrEn = 0; ctlWrPend = $urandom % 2; ctlWrIntEn = $urandom % 2;
      end
      #1;
      chk("R8 irq", irq, irqModel(pendFlag, intEnable, globalIntEn));
      // Model the coming edge
      tickExp = upcoming;
      if (upcoming) nTicks++;
      if (cycleEn) nEn++;
      if (upcoming) pendExp = 1'b1;
      else if (ctlWrEn && !ctlWrPend) pendExp = 1'b0;
      if (ctlWrEn) enExp = ctlWrIntEn;
    end

    // Directed R5: a write with pending bit 1 must leave a set flag alone.
    @(negedge clk);
    chk("R2 tick", tick, tickExp);
    chk("R5 pendFlag", pendFlag, pendExp);
    if (tickExp) nTicks = nTicks;
    cycleEn = 0; ctlWrEn = 1; ctlWrPend = 1; ctlWrIntEn = 1; globalIntEn = 1;
    @(negedge clk);
    chk("R5 write-one keeps flag", pendFlag, pendExp);
    chk("R7 enable written", intEnable, 1'b1);
    chk("R8 irq", irq, pendExp);
    ctlWrPend = 0;
    @(negedge clk);
    chk("R5 write-zero clears flag", pendFlag, 1'b0);
    chk("R8 irq low after clear", irq, 1'b0);
    ctlWrEn = 0;

    checks++;
    if (nTicks < 5 || nRace < 1) begin
      errors++;
      $display("FAIL R2 coverage: actual ticks %0d races %0d expected >=5 and >=1", nTicks, nRace);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule